// File: doc/BRIEF.md
# Colour Lookup Table Host Access Port

This block is the host side of a 256-entry colour lookup table. Each entry holds a red, a green and a blue value of up to 10 bits. The host talks to the block over a small parallel bus. A two-bit select input picks the target of each cycle, and single-cycle read and write strobes start the transfer. An 8-bit address register points at the current entry. The host loads a start address once and then streams colour values. A red/green/blue phase counter steps through the three components of the entry, and the address moves on by one each time a blue component completes.

Two configuration bits control the data format. The first picks 8-bit or 10-bit colour resolution. The second picks an 8-bit or 10-bit host data bus. On a narrow bus at full resolution, each colour value takes two bus cycles. The block stores the staged red and green values and writes the whole entry into the table in one go when its blue value is complete. Reads latch the addressed entry when the red component is read, so all three returned components come from the same entry.

A second, read-only lookup port returns the full 30-bit entry one clock after it is addressed. In 8-bit resolution the low bits of each colour on this port are forced to zero.

Top module: `pal_host_port`

## Requirements
- R1: Select code 00 targets the address register. A write loads `bus_wdata[7:0]` into it. A read returns it on `bus_rdata[7:0]` with bits 9..8 at zero, valid on the clock after the strobe.
- R2: Select code 01 targets the table. Three component writes (red, then green, then blue) store one entry. `lut_rgb` packs the entry as red in [29:20], green in [19:10] and blue in [9:0]. The entry in the table changes only when the blue value completes. After red and green alone, the lookup port still shows the old entry.
- R3: A write to the address register returns the phase counter to red and discards any partly written triplet.
- R4: Table reads return red, then green, then blue, one component per read strobe. All three come from the copy of the entry latched at the red read. After the blue read the address advances by one.
- R5: The address advances modulo 256, so it wraps from FFh to 00h after a triplet at FFh.
- R6: With 10-bit resolution and a 10-bit bus, full 10-bit colour values are written and read on `bus_wdata[9:0]` and `bus_rdata[9:0]`.
- R7: With 8-bit resolution, a colour value is taken from `bus_wdata[7:0]` and stored as the upper 8 bits with the two low bits at zero. Reads return the upper 8 bits on `bus_rdata[7:0]` with bits 9..8 at zero.
- R8: With 10-bit resolution on an 8-bit bus, each colour takes two writes. The first writes the upper 8 bits on `bus_wdata[7:0]`. The second writes the lower 2 bits on `bus_wdata[1:0]`. Reads return the upper 8 bits on `bus_rdata[7:0]` with bits 9..8 at zero.
- R9: While 8-bit resolution is selected, the two low bits of every colour on `lut_rgb` are zero, even for entries written in 10-bit resolution. `lut_rgb` updates one clock after `lut_addr`.
- R10: Select code 10 targets the configuration register. Bit 0 set selects 10-bit resolution and bit 1 set selects a 10-bit bus. A read returns both bits in the same positions. A write also returns the phase counter to red.
- R11: When both strobes are high in the same cycle, the write is performed and the read is ignored, so `bus_rdata` holds its value. Select code 11 is unused: a write to it changes nothing, and a read from it returns zero.
- R12: After reset the address is 00h, the phase is red, both configuration bits are 0, and `bus_rdata` and `lut_rgb` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Target select: 00 address, 01 table, 10 configuration, 11 unused |
| bus_wr | input | 1 | Write strobe, one cycle per transfer |
| bus_rd | input | 1 | Read strobe, one cycle per transfer |
| bus_wdata | input | 10 | Host write data |
| bus_rdata | output | 10 | Host read data, registered, held between reads |
| lut_addr | input | 8 | Lookup port entry address |
| lut_rgb | output | 30 | Lookup port entry {red, green, blue}, one cycle latency |

## Verification
The bench targets the commit point of a triplet. A design that wrote each colour into the table as it arrived would show a half-updated entry on the lookup port after red and green. It also checks that an address write or a configuration write in the middle of a triplet restarts the phase at red. A design that kept the old phase would put the next value into green. The split transfer on a narrow bus is exercised with distinct high and low parts, so swapped halves or a missing second cycle produce a wrong value. The address wrap at FFh, low-bit masking on the lookup port after a switch to 8-bit resolution, and simultaneous strobes are each driven directly. A faulty design would show a 9-bit address, stale low bits, or a read result that overwrites the held data.

// File: rtl/pal_pkg.sv
package pal_pkg;

   // Bus target select codes
   typedef enum logic [1:0] {
      SEL_ADDR = 2'b00,
      SEL_PAL  = 2'b01,
      SEL_CFG  = 2'b10,
      SEL_NONE = 2'b11
   } sel_e;

   // Component position inside a triplet
   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } phase_e;

   localparam int N_LANES = 3;

endpackage

// File: rtl/pal_cfg.sv
module pal_cfg #(
   parameter bit RES_WIDE_RST = 1'b0,
   parameter bit BUS_WIDE_RST = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       we_i,
   input  logic [1:0] wbits_i,
   output logic       res10_o,
   output logic       bus10_o
);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         res10_o <= RES_WIDE_RST;
         bus10_o <= BUS_WIDE_RST;
      end else if (we_i) begin
         res10_o <= wbits_i[0];
         bus10_o <= wbits_i[1];
      end
   end

endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
   parameter int ADDR_W = 8,
   parameter int ENT_W  = 30
) (
   input  logic              clk_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [ENT_W-1:0]  wentry_i,
   input  logic [ADDR_W-1:0] raddr_a_i,
   output logic [ENT_W-1:0]  rentry_a_o,
   input  logic [ADDR_W-1:0] raddr_b_i,
   output logic [ENT_W-1:0]  rentry_b_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [ENT_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) mem_q[waddr_i] <= wentry_i;
   end

   assign rentry_a_o = mem_q[raddr_a_i];
   assign rentry_b_o = mem_q[raddr_b_i];

endmodule

// File: rtl/pal_seq.sv
module pal_seq
   import pal_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int COL_W  = 10,
   parameter int NAR_W  = 8
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       wr_i,
   input  logic                       rd_i,
   input  logic [1:0]                 sel_i,
   input  logic [COL_W-1:0]           wdata_i,
   input  logic                       res10_i,
   input  logic                       bus10_i,
   input  logic [N_LANES*COL_W-1:0]   ram_q_i,
   output logic [ADDR_W-1:0]          addr_o,
   output logic [1:0]                 phase_o,
   output logic                       cfg_we_o,
   output logic                       ram_we_o,
   output logic [N_LANES*COL_W-1:0]   ram_wentry_o,
   output logic [COL_W-1:0]           rdata_o
);

   localparam int LSB_W = COL_W - NAR_W;
   localparam int ENT_W = N_LANES * COL_W;
   localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

   logic [ADDR_W-1:0] addr_q;
   phase_e            phase_q;
   logic              sub_q;
   logic [NAR_W-1:0]  hold_q;
   logic [COL_W-1:0]  red_q;
   logic [COL_W-1:0]  grn_q;
   logic [ENT_W-1:0]  lat_q;
   logic [COL_W-1:0]  rdata_q;

   // strobe decode, write has priority over read
   logic do_wr, do_rd;
   logic adr_wr, adr_rd, pal_wr, pal_rd, cfg_wr, cfg_rd, nul_rd;

   assign do_wr = wr_i;
   assign do_rd = rd_i && !wr_i;

   always_comb begin
      adr_wr = 1'b0; adr_rd = 1'b0;
      pal_wr = 1'b0; pal_rd = 1'b0;
      cfg_wr = 1'b0; cfg_rd = 1'b0;
      nul_rd = 1'b0;
      unique case (sel_e'(sel_i))
         SEL_ADDR: begin adr_wr = do_wr; adr_rd = do_rd; end
         SEL_PAL:  begin pal_wr = do_wr; pal_rd = do_rd; end
         SEL_CFG:  begin cfg_wr = do_wr; cfg_rd = do_rd; end
         default:  begin nul_rd = do_rd; end
      endcase
   end

   // data formatting
   logic two_step, first_half, wide_rd;
   logic [COL_W-1:0] wr_val;

   assign two_step   = res10_i && !bus10_i;
   assign first_half = two_step && !sub_q;
   assign wide_rd    = res10_i && bus10_i;

   always_comb begin
      if (two_step)
         wr_val = {hold_q, wdata_i[LSB_W-1:0]};
      else if (res10_i)
         wr_val = wdata_i;
      else
         wr_val = {wdata_i[NAR_W-1:0], {LSB_W{1'b0}}};
   end

   // per-lane read source: live table word at red, latched copy after
   logic [COL_W-1:0] src_lane [N_LANES];

   for (genvar g = 0; g < N_LANES; g++) begin : g_src
      assign src_lane[g] = (phase_q == PH_RED) ? ram_q_i[g*COL_W +: COL_W]
                                               : lat_q[g*COL_W +: COL_W];
   end

   logic [COL_W-1:0] comp, rd_fmt;

   always_comb begin
      unique case (phase_q)
         PH_RED:  comp = src_lane[N_LANES-1];
         PH_GRN:  comp = src_lane[N_LANES-2];
         default: comp = src_lane[0];
      endcase
      rd_fmt = wide_rd ? comp : {{LSB_W{1'b0}}, comp[COL_W-1:LSB_W]};
   end

   function automatic phase_e next_phase(input phase_e p);
      unique case (p)
         PH_RED:  return PH_GRN;
         PH_GRN:  return PH_BLU;
         default: return PH_RED;
      endcase
   endfunction

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         addr_q  <= '0;
         phase_q <= PH_RED;
         sub_q   <= 1'b0;
         hold_q  <= '0;
         red_q   <= '0;
         grn_q   <= '0;
         lat_q   <= '0;
         rdata_q <= '0;
      end else if (adr_wr) begin
         addr_q  <= wdata_i[ADDR_W-1:0];
         phase_q <= PH_RED;
         sub_q   <= 1'b0;
      end else if (cfg_wr) begin
         phase_q <= PH_RED;
         sub_q   <= 1'b0;
      end else if (pal_wr) begin
         if (first_half) begin
            hold_q <= wdata_i[NAR_W-1:0];
            sub_q  <= 1'b1;
         end else begin
            sub_q   <= 1'b0;
            phase_q <= next_phase(phase_q);
            unique case (phase_q)
               PH_RED:  red_q  <= wr_val;
               PH_GRN:  grn_q  <= wr_val;
               default: addr_q <= addr_q + ADDR_ONE;
            endcase
         end
      end else if (pal_rd) begin
         sub_q   <= 1'b0;
         rdata_q <= rd_fmt;
         phase_q <= next_phase(phase_q);
         if (phase_q == PH_RED) lat_q  <= ram_q_i;
         if (phase_q == PH_BLU) addr_q <= addr_q + ADDR_ONE;
      end else if (adr_rd) begin
         rdata_q <= {{(COL_W-ADDR_W){1'b0}}, addr_q};
      end else if (cfg_rd) begin
         rdata_q <= {{(COL_W-2){1'b0}}, bus10_i, res10_i};
      end else if (nul_rd) begin
         rdata_q <= '0;
      end
   end

   assign ram_we_o     = pal_wr && !first_half && (phase_q == PH_BLU);
   assign ram_wentry_o = {red_q, grn_q, wr_val};
   assign cfg_we_o     = cfg_wr;
   assign addr_o       = addr_q;
   assign phase_o      = phase_q;
   assign rdata_o      = rdata_q;

endmodule

// File: rtl/pal_host_port.sv
module pal_host_port
   import pal_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int COL_W        = 10,
   parameter int NAR_W        = 8,
   parameter bit RES_WIDE_RST = 1'b0,
   parameter bit BUS_WIDE_RST = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             bus_sel,
   input  logic                   bus_wr,
   input  logic                   bus_rd,
   input  logic [COL_W-1:0]       bus_wdata,
   output logic [COL_W-1:0]       bus_rdata,
   input  logic [ADDR_W-1:0]      lut_addr,
   output logic [3*COL_W-1:0]     lut_rgb
);

   localparam int LSB_W = COL_W - NAR_W;
   localparam int ENT_W = N_LANES * COL_W;

   if (COL_W <= NAR_W || COL_W > 2 * NAR_W) begin : g_bad_col
      $error("COL_W must exceed NAR_W and fit in two narrow transfers");
   end
   if (ADDR_W < 1 || ADDR_W > NAR_W || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W must fit the narrow bus and keep the table small");
   end

   logic              res10, bus10, cfg_we, ram_we;
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        phase_q;
   logic [ENT_W-1:0]  ram_wentry, ram_host_q, lut_raw, lut_d, lut_q;

   pal_cfg #(
      .RES_WIDE_RST (RES_WIDE_RST),
      .BUS_WIDE_RST (BUS_WIDE_RST)
   ) u_cfg (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .we_i    (cfg_we),
      .wbits_i (bus_wdata[1:0]),
      .res10_o (res10),
      .bus10_o (bus10)
   );

   pal_seq #(
      .ADDR_W (ADDR_W),
      .COL_W  (COL_W),
      .NAR_W  (NAR_W)
   ) u_seq (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .wr_i         (bus_wr),
      .rd_i         (bus_rd),
      .sel_i        (bus_sel),
      .wdata_i      (bus_wdata),
      .res10_i      (res10),
      .bus10_i      (bus10),
      .ram_q_i      (ram_host_q),
      .addr_o       (addr_q),
      .phase_o      (phase_q),
      .cfg_we_o     (cfg_we),
      .ram_we_o     (ram_we),
      .ram_wentry_o (ram_wentry),
      .rdata_o      (bus_rdata)
   );

   pal_ram #(
      .ADDR_W (ADDR_W),
      .ENT_W  (ENT_W)
   ) u_ram (
      .clk_i      (clk),
      .we_i       (ram_we),
      .waddr_i    (addr_q),
      .wentry_i   (ram_wentry),
      .raddr_a_i  (addr_q),
      .rentry_a_o (ram_host_q),
      .raddr_b_i  (lut_addr),
      .rentry_b_o (lut_raw)
   );

   // lookup lanes: low bits cleared in narrow resolution
   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      assign lut_d[g*COL_W +: COL_W] = res10 ? lut_raw[g*COL_W +: COL_W]
                                             : {lut_raw[g*COL_W+LSB_W +: NAR_W], {LSB_W{1'b0}}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lut_q <= '0;
      else        lut_q <= lut_d;
   end

   assign lut_rgb = lut_q;

endmodule

// File: rtl/pal_host_port_chk.sv
module pal_host_port_chk #(
   parameter int ADDR_W = 8,
   parameter int COL_W  = 10,
   parameter int NAR_W  = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr,
   input logic                 rd,
   input logic [1:0]           sel,
   input logic [COL_W-1:0]     wdata,
   input logic [COL_W-1:0]     rdata,
   input logic [ADDR_W-1:0]    addr,
   input logic [1:0]           phase,
   input logic                 ram_we,
   input logic                 res10,
   input logic [3*COL_W-1:0]   lut
);

   localparam int LSB_W = COL_W - NAR_W;
   localparam logic [ADDR_W-1:0] ONE = 1;

   function automatic logic [3*COL_W-1:0] low_mask();
      logic [3*COL_W-1:0] m;
      m = '0;
      for (int i = 0; i < 3; i++) m[i*COL_W +: LSB_W] = '1;
      return m;
   endfunction

   localparam logic [3*COL_W-1:0] LOW_MASK = low_mask();

   p_addr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == 2'b00) |=> (addr == $past(wdata[ADDR_W-1:0])));

   p_addr_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !wr && sel == 2'b00) |=> (rdata == {{(COL_W-ADDR_W){1'b0}}, $past(addr)}));

   p_phase_red_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == 2'b00) |=> (phase == 2'd0));

   p_phase_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      phase != 2'd3);

   p_commit_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> (addr == $past(addr) + ONE));

   p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd || wr) |=> $stable(rdata));

   p_unused_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == 2'b11) |=> $stable(addr));

   p_lut_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !res10 |=> ((lut & LOW_MASK) == '0));

   p_cfg_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == 2'b10) |=> (phase == 2'd0 && res10 == $past(wdata[0])));

endmodule

bind pal_host_port pal_host_port_chk #(
   .ADDR_W (ADDR_W),
   .COL_W  (COL_W),
   .NAR_W  (NAR_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr     (bus_wr),
   .rd     (bus_rd),
   .sel    (bus_sel),
   .wdata  (bus_wdata),
   .rdata  (bus_rdata),
   .addr   (addr_q),
   .phase  (phase_q),
   .ram_we (ram_we),
   .res10  (res10),
   .lut    (lut_rgb)
);

// File: tb/sim_pal_host_port.sv
module sim_pal_host_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_sel = 2'b00;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [9:0]  bus_wdata = '0;
   logic [9:0]  bus_rdata;
   logic [7:0]  lut_addr = '0;
   logic [29:0] lut_rgb;

   always #10 clk = ~clk;   // 50 MHz

   pal_host_port u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .lut_addr  (lut_addr),
      .lut_rgb   (lut_rgb)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R12";

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_mem [0:767];
   bit m_ok  [0:255];
   int m_addr, m_phase, m_sub, m_res10, m_bus10, m_hold, m_r, m_g;
   int m_lat [0:2];
   int m_rdata, m_lut;
   bit m_lut_ok;

   function automatic int fmt_rd(input int c);
      return (m_res10 == 1 && m_bus10 == 1) ? c : (c >> 2);
   endfunction

   function automatic int lane_out(input int c);
      return (m_res10 == 1) ? c : (c & 10'h3FC);
   endfunction

   always @(posedge clk) begin
      int v, la, w, s;
      bit two;
      w = int'(bus_wdata);
      s = int'(bus_sel);
      if (!rst_n) begin
         m_addr = 0; m_phase = 0; m_sub = 0; m_res10 = 0; m_bus10 = 0;
         m_hold = 0; m_r = 0; m_g = 0; m_rdata = 0; m_lut = 0; m_lut_ok = 1'b1;
         m_lat[0] = 0; m_lat[1] = 0; m_lat[2] = 0;
      end else begin
         la = int'(lut_addr);
         m_lut_ok = m_ok[la];
         m_lut = (lane_out(m_mem[la*3]) << 20) | (lane_out(m_mem[la*3+1]) << 10)
               | lane_out(m_mem[la*3+2]);
         two = (m_res10 == 1 && m_bus10 == 0);
         if (bus_wr) begin
            if (s == 0) begin
               m_addr = w & 255; m_phase = 0; m_sub = 0;
            end else if (s == 2) begin
               m_res10 = w & 1; m_bus10 = (w >> 1) & 1; m_phase = 0; m_sub = 0;
            end else if (s == 1) begin
               if (two && m_sub == 0) begin
                  m_hold = w & 255; m_sub = 1;
               end else begin
                  if (two)               v = m_hold * 4 + (w & 3);
                  else if (m_res10 == 1) v = w;
                  else                   v = (w & 255) * 4;
                  m_sub = 0;
                  if (m_phase == 0) begin m_r = v; m_phase = 1; end
                  else if (m_phase == 1) begin m_g = v; m_phase = 2; end
                  else begin
                     m_mem[m_addr*3] = m_r; m_mem[m_addr*3+1] = m_g; m_mem[m_addr*3+2] = v;
                     m_ok[m_addr] = 1'b1;
                     m_addr = (m_addr + 1) % 256; m_phase = 0;
                  end
               end
            end
         end else if (bus_rd) begin
            if (s == 0) m_rdata = m_addr;
            else if (s == 2) m_rdata = m_bus10 * 2 + m_res10;
            else if (s == 3) m_rdata = 0;
            else begin
               m_sub = 0;
               if (m_phase == 0)
                  for (int k = 0; k < 3; k++) m_lat[k] = m_mem[m_addr*3+k];
               m_rdata = fmt_rd(m_lat[m_phase]);
               if (m_phase == 2) begin m_addr = (m_addr + 1) % 256; m_phase = 0; end
               else m_phase = m_phase + 1;
            end
         end
      end
   end

   // per-clock comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, 32'(bus_rdata), 32'(m_rdata));
         if (m_lut_ok) chk(cur_req, 32'(lut_rgb), 32'(m_lut));
      end
   end

   // ---------------- bus tasks (entered at a falling edge) ----------------
   task automatic bw(input logic [1:0] s, input logic [9:0] d);
      bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic br(input logic [1:0] s, output logic [9:0] v);
      bus_sel = s; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   task automatic look(input logic [7:0] a, output logic [29:0] v);
      lut_addr = a;
      @(negedge clk);
      v = lut_rgb;
   endtask

   function automatic logic [29:0] pack(input int r, input int g, input int b);
      return 30'((r << 20) | (g << 10) | b);
   endfunction

   initial begin
      logic [9:0]  v;
      logic [29:0] e;
      for (int i = 0; i < 768; i++) m_mem[i] = 0;
      for (int i = 0; i < 256; i++) m_ok[i] = 1'b0;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12", 32'(bus_rdata), 0);
      chk("R12", 32'(lut_rgb), 0);
      rst_n = 1'b1;
      @(negedge clk);
      br(2'b00, v); chk("R12", 32'(v), 0);
      br(2'b10, v); chk("R12", 32'(v), 0);

      // R1 address register
      cur_req = "R1";
      bw(2'b00, 10'h3A5);
      br(2'b00, v); chk("R1", 32'(v), 32'h0A5);

      // R10 configuration register
      cur_req = "R10";
      bw(2'b10, 10'h003);
      br(2'b10, v); chk("R10", 32'(v), 3);

      // R6 / R2 full-width triplet and commit point
      cur_req = "R2";
      bw(2'b00, 10'h010);
      bw(2'b01, 10'h111); bw(2'b01, 10'h222); bw(2'b01, 10'h333);
      look(8'h10, e); chk("R6", 32'(e), 32'(pack('h111, 'h222, 'h333)));
      bw(2'b00, 10'h010);
      bw(2'b01, 10'h2A5); bw(2'b01, 10'h15A);
      look(8'h10, e); chk("R2", 32'(e), 32'(pack('h111, 'h222, 'h333)));
      bw(2'b01, 10'h3C3);
      look(8'h10, e); chk("R2", 32'(e), 32'(pack('h2A5, 'h15A, 'h3C3)));
      br(2'b00, v); chk("R2", 32'(v), 32'h011);

      // R4 sequential read
      cur_req = "R4";
      bw(2'b00, 10'h010);
      br(2'b01, v); chk("R4", 32'(v), 32'h2A5);
      br(2'b01, v); chk("R4", 32'(v), 32'h15A);
      br(2'b01, v); chk("R4", 32'(v), 32'h3C3);
      br(2'b00, v); chk("R4", 32'(v), 32'h011);

      // R3 address write mid-triplet restarts at red
      cur_req = "R3";
      bw(2'b00, 10'h020);
      bw(2'b01, 10'h001);
      bw(2'b00, 10'h020);
      bw(2'b01, 10'h100); bw(2'b01, 10'h200); bw(2'b01, 10'h300);
      look(8'h20, e); chk("R3", 32'(e), 32'(pack('h100, 'h200, 'h300)));

      // R5 wrap
      cur_req = "R5";
      bw(2'b00, 10'h0FF);
      bw(2'b01, 10'h005); bw(2'b01, 10'h006); bw(2'b01, 10'h007);
      br(2'b00, v); chk("R5", 32'(v), 0);

      // R8 10-bit colour over 8-bit bus
      cur_req = "R8";
      bw(2'b10, 10'h001);
      bw(2'b00, 10'h030);
      bw(2'b01, 10'h0AB); bw(2'b01, 10'h002);
      bw(2'b01, 10'h012); bw(2'b01, 10'h001);
      bw(2'b01, 10'h0FF); bw(2'b01, 10'h003);
      look(8'h30, e); chk("R8", 32'(e), 32'(pack('h2AE, 'h049, 'h3FF)));
      bw(2'b00, 10'h030);
      br(2'b01, v); chk("R8", 32'(v), 32'h0AB);
      br(2'b01, v); chk("R8", 32'(v), 32'h012);
      br(2'b01, v); chk("R8", 32'(v), 32'h0FF);

      // R7 8-bit resolution
      cur_req = "R7";
      bw(2'b10, 10'h000);
      bw(2'b00, 10'h040);
      bw(2'b01, 10'h311); bw(2'b01, 10'h080); bw(2'b01, 10'h00F);
      look(8'h40, e); chk("R7", 32'(e), 32'(pack('h044, 'h200, 'h03C)));
      bw(2'b00, 10'h040);
      br(2'b01, v); chk("R7", 32'(v), 32'h011);
      br(2'b01, v); chk("R7", 32'(v), 32'h080);
      br(2'b01, v); chk("R7", 32'(v), 32'h00F);

      // R9 low bits masked on lookup in 8-bit resolution
      cur_req = "R9";
      look(8'h10, e); chk("R9", 32'(e), 32'(pack('h2A4, 'h158, 'h3C0)));

      // R11 simultaneous strobes and unused select
      cur_req = "R11";
      br(2'b10, v);
      bus_sel = 2'b00; bus_wdata = 10'h055; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      chk("R11", 32'(bus_rdata), 0);
      bw(2'b11, 10'h077);
      br(2'b00, v); chk("R11", 32'(v), 32'h055);
      br(2'b11, v); chk("R11", 32'(v), 0);

      // R10 configuration write restarts at red
      cur_req = "R10";
      bw(2'b00, 10'h050);
      bw(2'b01, 10'h0EE);
      bw(2'b10, 10'h003);
      bw(2'b01, 10'h001); bw(2'b01, 10'h002); bw(2'b01, 10'h003);
      look(8'h50, e); chk("R10", 32'(e), 32'(pack(1, 2, 3)));

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R12 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule